// File: doc/BRIEF.md
# Parity-Encoded Control State Machine with Concurrent Error Check

This block is a small four-state control sequencer whose state register holds one extra bit. The extra bit sits above the two binary state bits and makes every legal encoded state have odd parity. The binary codes of the states stay as they are, so other logic can take the two low bits and decode them directly. The machine also predicts the parity of its own control outputs. One XOR tree covers the state register, the control outputs and the predicted parity bit. Because of that, a single-bit upset in the state register is flagged in the same cycle the corrupted value sits in the register.

The example machine waits in idle until `start`. It then takes one load cycle and stays in a run phase until `halt`, where each `step` produces an advance pulse. It spends one cycle in done and returns to idle. Any code with even parity leads to done on the next edge. An error-injection mask XORs into the state register at the clock edge, so upsets can be produced on purpose. The combinational error flag comes with a registered sticky copy that only reset clears. Flips of an even number of bits can go unseen. This limit of a single parity bit is accepted.

Top module: `ced_parity_fsm`

## Requirements
- R1: A clock edge with `rst` high loads the encoded idle state 3'b100. In the following cycle, with all inputs low, `phase`=2'b00, `ctl`=5'b00001, and `err` and `err_sticky` are 0. The reset input overrides the injection mask.
- R2: The register's top bit is a parity bit and its two low bits are the binary state, shown on `phase`. Idle is 00 (encoded 100), load is 01 (encoded 001), run is 10 (encoded 010) and done is 11 (encoded 111). Every legal code has odd parity.
- R3: From idle, `start` moves to load; without it the machine stays in idle. Load always moves to run. Run moves to done on `halt` and otherwise stays in run. Done always moves to idle.
- R4: `ctl` bit 0 is ready (idle), bit 1 is busy (load and run), bit 2 is load (load), bit 3 is done (done) and bit 4 is advance (run with `step`). Any code with even parity drives `ctl` to all zeros.
- R5: `ctl_par` is predicted from the state code and `step` alone. For every register code and every input it equals the XOR of the five `ctl` bits.
- R6: `err` is the inverted XOR over the state register, `ctl` and `ctl_par`. It is 0 whenever the register holds a legal code. It is 1 in the very cycle the register holds a code with a single bit flipped.
- R7: A register code with even parity moves to done (encoded 111) at the next edge.
- R8: A double-bit flip that lands on another legal code (for example 100 to 111 or 100 to 001) leaves `err` at 0.
- R9: `err_sticky` goes to 1 at the edge after a cycle with `err`=1. It then stays at 1 until an edge with `rst` high.
- R10: At an edge with `rst` low, the register loads the next-state code XORed with `flip_mask`. At an edge with `rst` high, `flip_mask` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leave idle for load |
| step | input | 1 | Advance request while in run |
| halt | input | 1 | Finish run |
| flip_mask | input | 3 | Error-injection mask XORed into the state register at the edge |
| ctl | output | 5 | Control outputs {advance, done, load, busy, ready} |
| ctl_par | output | 1 | Predicted parity of `ctl` |
| phase | output | 2 | Binary state bits, without the parity bit |
| err | output | 1 | Combined parity check failed this cycle |
| err_sticky | output | 1 | Registered error flag, held until reset |

## Verification
The bench builds the block with its only configuration: a two-bit binary state, a three-bit encoded register and five control bits. At that size every one of the eight register codes can be planted through the injection mask, and each code can be driven with all eight combinations of `start`, `step` and `halt`. That covers the whole next-state and output space, including every illegal code. A long pseudo-random run then mixes single-bit and double-bit injections with resets. The tracking model in the bench checks the same-cycle detection, the miss on legal-to-legal double flips and the behaviour of the sticky flag.

// File: rtl/ced_fsm_pkg.sv
package ced_fsm_pkg;

    localparam int PHASE_W = 2;
    localparam int ENC_W   = PHASE_W + 1;
    localparam int CTL_W   = 5;
    localparam int CHK_W   = ENC_W + CTL_W + 1;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [ENC_W-1:0]   enc_t;
    typedef logic [CTL_W-1:0]   ctl_t;

    // odd-parity code: parity bit on top, binary state unchanged below
    function automatic enc_t encode(input phase_t p);
        return {~^p, p};
    endfunction

    localparam enc_t S_IDLE = encode(2'b00);
    localparam enc_t S_LOAD = encode(2'b01);
    localparam enc_t S_RUN  = encode(2'b10);
    localparam enc_t S_DONE = encode(2'b11);

    localparam int CTL_READY = 0;
    localparam int CTL_BUSY  = 1;
    localparam int CTL_LOAD  = 2;
    localparam int CTL_DONE  = 3;
    localparam int CTL_ADV   = 4;

    typedef struct packed {
        enc_t state;
        logic sticky;
    } regs_t;

endpackage

// File: rtl/ced_fsm_next.sv
module ced_fsm_next
    import ced_fsm_pkg::*;
(
    input  enc_t state_i,
    input  logic start_i,
    input  logic halt_i,
    output enc_t next_o
);

    always_comb begin
        case (state_i)
            S_IDLE:  next_o = start_i ? S_LOAD : S_IDLE;
            S_LOAD:  next_o = S_RUN;
            S_RUN:   next_o = halt_i ? S_DONE : S_RUN;
            S_DONE:  next_o = S_IDLE;
            default: next_o = S_DONE;
        endcase
    end

endmodule

// File: rtl/ced_fsm_out.sv
module ced_fsm_out
    import ced_fsm_pkg::*;
(
    input  enc_t state_i,
    input  logic step_i,
    output ctl_t ctl_o,
    output logic ctl_par_o
);

    // control decode
    always_comb begin
        ctl_o = '0;
        case (state_i)
            S_IDLE: ctl_o[CTL_READY] = 1'b1;
            S_LOAD: begin
                ctl_o[CTL_BUSY] = 1'b1;
                ctl_o[CTL_LOAD] = 1'b1;
            end
            S_RUN: begin
                ctl_o[CTL_BUSY] = 1'b1;
                ctl_o[CTL_ADV]  = step_i;
            end
            S_DONE:  ctl_o[CTL_DONE] = 1'b1;
            default: ctl_o = '0;
        endcase
    end

    // parity prediction, derived per state rather than from ctl_o
    always_comb begin
        case (state_i)
            S_IDLE:  ctl_par_o = 1'b1;
            S_LOAD:  ctl_par_o = 1'b0;
            S_RUN:   ctl_par_o = ~step_i;
            S_DONE:  ctl_par_o = 1'b1;
            default: ctl_par_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ced_par_check.sv
module ced_par_check #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits_i,
    output logic         err_o
);

    logic [W-1:0] acc;

    assign acc[0] = bits_i[0];
    for (genvar i = 1; i < W; i++) begin : g_xor
        assign acc[i] = acc[i-1] ^ bits_i[i];
    end

    // state parity is odd, output parity even: combined parity must be 1
    assign err_o = ~acc[W-1];

endmodule

// File: rtl/ced_parity_fsm.sv
module ced_parity_fsm
    import ced_fsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               step,
    input  logic               halt,
    input  logic [ENC_W-1:0]   flip_mask,
    output logic [CTL_W-1:0]   ctl,
    output logic               ctl_par,
    output logic [PHASE_W-1:0] phase,
    output logic               err,
    output logic               err_sticky
);

    regs_t r_d, r_q;
    enc_t  nxt;

    ced_fsm_next i_next (
        .state_i (r_q.state),
        .start_i (start),
        .halt_i  (halt),
        .next_o  (nxt)
    );

    ced_fsm_out i_out (
        .state_i   (r_q.state),
        .step_i    (step),
        .ctl_o     (ctl),
        .ctl_par_o (ctl_par)
    );

    ced_par_check #(.W(CHK_W)) i_chk_tree (
        .bits_i ({r_q.state, ctl, ctl_par}),
        .err_o  (err)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.state  = S_IDLE;
            r_d.sticky = 1'b0;
        end else begin
            r_d.state  = nxt ^ flip_mask;
            r_d.sticky = r_q.sticky | err;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign phase      = r_q.state[PHASE_W-1:0];
    assign err_sticky = r_q.sticky;

endmodule

// File: rtl/ced_parity_fsm_chk.sv
module ced_parity_fsm_chk
    import ced_fsm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [ENC_W-1:0]   flip_mask,
    input logic [CTL_W-1:0]   ctl,
    input logic               ctl_par,
    input logic [PHASE_W-1:0] phase,
    input logic               err,
    input logic               err_sticky
);

    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(rst) |-> (phase == 2'b00 && !err && !err_sticky && ctl == 5'b00001));

    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (phase == 2'b00 && !err && start && flip_mask == '0) |=> (phase == 2'b01));

    // R5
    ctl_parity_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ctl_par == ^ctl);

    // R6
    single_flip_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!$past(rst) && $countones($past(flip_mask)) == 1) |-> err);

    // R6
    no_false_err_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!$past(rst) && $past(flip_mask) == '0 && !$past(err)) |-> !err);

    // R7
    illegal_to_done_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (err && flip_mask == '0) |=> (phase == 2'b11 && !err));

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        err |=> err_sticky);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        err_sticky |=> err_sticky);

endmodule

bind ced_parity_fsm ced_parity_fsm_chk i_ced_parity_fsm_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .flip_mask  (flip_mask),
    .ctl        (ctl),
    .ctl_par    (ctl_par),
    .phase      (phase),
    .err        (err),
    .err_sticky (err_sticky)
);

// File: tb/test_ced_parity_fsm.sv
`timescale 1ns/1ps
module test_ced_parity_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, step = 1'b0, halt = 1'b0;
    logic [2:0] flip_mask = 3'b000;
    logic [4:0] ctl;
    logic       ctl_par;
    logic [1:0] phase;
    logic       err, err_sticky;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done_run = 1'b0;

    logic [2:0]  m_enc = 3'b100;
    logic        m_stk = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    ced_parity_fsm i_ced_parity_fsm (
        .clk(clk), .rst(rst), .start(start), .step(step), .halt(halt),
        .flip_mask(flip_mask), .ctl(ctl), .ctl_par(ctl_par), .phase(phase),
        .err(err), .err_sticky(err_sticky)
    );

    // model from R3/R7
    function automatic logic [2:0] m_next(input logic [2:0] s, input logic st, input logic ht);
        case (s)
            3'b100:  return st ? 3'b001 : 3'b100;
            3'b001:  return 3'b010;
            3'b010:  return ht ? 3'b111 : 3'b010;
            3'b111:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    // model from R4
    function automatic logic [4:0] m_ctl(input logic [2:0] s, input logic sp);
        case (s)
            3'b100:  return 5'b00001;
            3'b001:  return 5'b00110;
            3'b010:  return {sp, 4'b0010};
            3'b111:  return 5'b01000;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (code=%b)", tag, act, exp, m_enc);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // one cycle: drive, check outputs before the edge, advance the model
    task automatic cyc(input logic r, input logic st, input logic sp, input logic ht,
                       input logic [2:0] mask, input string tg);
        logic m_err;
        @(negedge clk);
        rst = r; start = st; step = sp; halt = ht; flip_mask = mask;
        #1;
        m_err = ~^m_enc;
        chk((tg == "") ? "R2 phase" : tg, 32'(phase), 32'(m_enc[1:0]));
        chk((tg == "") ? "R6 err" : tg, 32'(err), 32'(m_err));
        chk("R4 ctl", 32'(ctl), 32'(m_ctl(m_enc, sp)));
        chk("R5 ctl_par", 32'(ctl_par), 32'(^m_ctl(m_enc, sp)));
        chk((tg == "") ? "R9 sticky" : tg, 32'(err_sticky), 32'(m_stk));
        @(posedge clk);
        if (r) begin
            m_enc = 3'b100;
            m_stk = 1'b0;
        end else begin
            m_stk = m_stk | m_err;
            m_enc = m_next(m_enc, st, ht) ^ mask;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        m_enc = 3'b100;
        m_stk = 1'b0;

        // R1: state after reset
        cyc(0, 0, 0, 0, 3'b000, "R1");

        // R10: reset overrides the mask
        cyc(0, 0, 0, 0, 3'b001, "");
        cyc(1, 0, 0, 0, 3'b001, "R6 err before reset");
        cyc(0, 0, 0, 0, 3'b000, "R10");

        // exhaustive: plant every code, apply every input combination
        for (int code = 0; code < 8; code++) begin
            for (int in = 0; in < 8; in++) begin
                logic legal;
                legal = ^code[2:0];
                cyc(1, 0, 0, 0, 3'b000, "R1");
                cyc(0, 0, 0, 0, code[2:0] ^ 3'b100, "");
                cyc(0, in[0], in[1], in[2], 3'b000, legal ? "" : "R6 detect");
                cyc(0, 0, 0, 0, 3'b000, legal ? "R3" : "R7");
            end
        end

        // R8: double flips onto legal codes go unseen
        cyc(1, 0, 0, 0, 3'b000, "");
        cyc(0, 0, 0, 0, 3'b011, "");
        cyc(0, 0, 0, 0, 3'b000, "R8 to 111");
        cyc(1, 0, 0, 0, 3'b000, "");
        cyc(0, 0, 0, 0, 3'b101, "");
        cyc(0, 0, 0, 0, 3'b000, "R8 to 001");

        // R9: sticky survives return to legal codes
        cyc(0, 0, 0, 0, 3'b010, "");
        cyc(0, 0, 0, 0, 3'b000, "R6 single");
        cyc(0, 0, 0, 0, 3'b000, "R9 set");
        cyc(0, 1, 0, 0, 3'b000, "R9 hold");

        // long mixed run
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] mk;
            logic r;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mk = 3'b000;
            if (lf[9:6] == 4'd0) begin
                case (lf[1:0])
                    2'd0:    mk = 3'b001;
                    2'd1:    mk = 3'b010;
                    default: mk = 3'b100;
                endcase
            end else if (lf[9:6] == 4'd1) begin
                mk = 3'b011;
            end
            r = (lf[15:11] == 5'd0);
            cyc(r, lf[2], lf[3], lf[4], mk, "");
        end

        done_run = 1'b1;
        finish_run();
    end

endmodule